// File: doc/BRIEF.md
# Bit-Select Bus Fan-Out Mux

This block connects one bus master to a set of slaves on a single-beat, classic-cycle Wishbone bus. Each slave is selected by one address bit of its own, placed above the slave's local address field, so the address decode is one priority pick and no range comparators are needed. The block sends the strobe only to the selected slave. It passes the lower address bits, write enable, byte selects and write data to all slaves. It returns the selected slave's acknowledge, error and read data to the master.

If no select bit is set on a strobed cycle, the block answers the master with an error itself. A build parameter places a register stage between the mux and the slave-side buses. This helps timing when slaves sit far apart, but each transfer then costs extra cycles. In that mode only one request is in flight at a time.

Top module: `bitsel_bus_mux`

## Requirements
- R1: Master address bit `LOW_AW+i` selects slave i. The selected slave alone gets `s_cyc[i]` and `s_stb[i]` high.
- R2: When several select bits are set, the slave on the lowest-numbered bit wins.
- R3: At most one slave sees cyc or stb at any time. Every other slave sees both low.
- R4: While the master's cyc or stb is low, no slave sees stb high, and the master sees no ack.
- R5: `s_adr` carries master address bits `[LOW_AW-1:0]` and excludes the select bits. `s_we`, `s_sel` and `s_dat_w` carry the master's values unchanged.
- R6: `m_ack`, `m_err` and `m_dat_r` come only from the selected slave. Slave i's read data sits at `s_dat_r[i*DW +: DW]`. Ack or err from slaves that are not selected is ignored.
- R7: A strobed cycle with all select bits low raises `m_err` and strobes no slave. This happens in the same cycle with `REG_OUT=0` and in the next cycle with `REG_OUT=1`.
- R8: With `REG_OUT=0` the block holds no state. The slave strobes and master responses follow the current inputs with no clock edge between them.
- R9: With `REG_OUT=1` the slave strobe, address and data appear one cycle after the master's request. A slave answer reaches the master one cycle after the slave gives it.
- R10: With `REG_OUT=1`, ack or err reaches the master for exactly one cycle per request. While the block waits for a slave, the forwarded request stays stable and no new request is taken.
- R11: With `REG_OUT=1`, if the master drops cyc while waiting, the slave cyc and stb fall at the next edge and no ack is returned.
- R12: With `REG_OUT=1`, after reset every slave cyc/stb and the master ack/err are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_cyc | input | 1 | Master cycle valid |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | LOW_AW+N_SLV | Master address; bit LOW_AW+i selects slave i |
| m_dat_w | input | DW | Master write data |
| m_sel | input | DW/8 | Master byte selects |
| m_ack | output | 1 | Acknowledge to master |
| m_err | output | 1 | Error to master |
| m_dat_r | output | DW | Read data to master |
| s_cyc | output | N_SLV | Per-slave cycle valid |
| s_stb | output | N_SLV | Per-slave strobe |
| s_we | output | 1 | Shared write enable |
| s_adr | output | LOW_AW | Shared local address |
| s_dat_w | output | DW | Shared write data |
| s_sel | output | DW/8 | Shared byte selects |
| s_ack | input | N_SLV | Per-slave acknowledge |
| s_err | input | N_SLV | Per-slave error |
| s_dat_r | input | N_SLV*DW | Packed per-slave read data |

## Verification
The bench builds two copies side by side, both with four slaves, a 4-bit local address and 16-bit data. One copy has `REG_OUT=0` and the other has `REG_OUT=1`.

Four slaves allow overlapping select patterns, such as two, three or all bits set, which exercise the lowest-bit priority. They also allow acks from slaves that are not selected to be driven at the same time. The combinational copy is checked between clock edges, which shows that it holds no state.

The registered copy makes the one-cycle delays visible on each side. It also covers the hold while a slave is slow, the single-cycle response, an abort by the master, and the self-generated error.

// File: rtl/bitsel_mux_pkg.sv
package bitsel_mux_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } mux_state_e;

endpackage

// File: rtl/bitsel_pick.sv
module bitsel_pick #(
    parameter int N_SLV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SLV-1:0] bits,
    output logic [N_SLV-1:0] win,
    output logic             none
);
    logic seen;

    always_comb begin
        seen = 1'b0;
        win  = '0;
        for (int i = 0; i < N_SLV; i++) begin
            win[i] = bits[i] & ~seen;
            seen   = seen | bits[i];
        end
        none = ~seen;
    end

    // R2: no lower bit than the winner is set, and the winner is among the set bits
    a_r2_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (win != '0) |-> ((((win - 1'b1) & bits) == '0) && ((win & bits) == win)));

    // R3: at most one winner
    a_r3_single_win: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win));

endmodule

// File: rtl/bitsel_gather.sv
module bitsel_gather #(
    parameter int N_SLV = 4,
    parameter int DW    = 16
) (
    input  logic [N_SLV-1:0]    grant,
    input  logic [N_SLV-1:0]    s_ack,
    input  logic [N_SLV-1:0]    s_err,
    input  logic [N_SLV*DW-1:0] s_dat_r,
    output logic                g_ack,
    output logic                g_err,
    output logic [DW-1:0]       g_dat
);
    always_comb begin
        g_ack = 1'b0;
        g_err = 1'b0;
        g_dat = '0;
        for (int i = 0; i < N_SLV; i++) begin
            if (grant[i]) begin
                g_ack = g_ack | s_ack[i];
                g_err = g_err | s_err[i];
                g_dat = g_dat | s_dat_r[i*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/bitsel_comb_path.sv
module bitsel_comb_path #(
    parameter int N_SLV  = 4,
    parameter int LOW_AW = 4,
    parameter int DW     = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_SLV-1:0]    win,
    input  logic                none,
    input  logic                m_cyc,
    input  logic                m_stb,
    input  logic                m_we,
    input  logic [LOW_AW-1:0]   m_adr_low,
    input  logic [DW-1:0]       m_dat_w,
    input  logic [DW/8-1:0]     m_sel,
    output logic                m_ack,
    output logic                m_err,
    output logic [DW-1:0]       m_dat_r,
    output logic [N_SLV-1:0]    s_cyc,
    output logic [N_SLV-1:0]    s_stb,
    output logic                s_we,
    output logic [LOW_AW-1:0]   s_adr,
    output logic [DW-1:0]       s_dat_w,
    output logic [DW/8-1:0]     s_sel,
    input  logic [N_SLV-1:0]    s_ack,
    input  logic [N_SLV-1:0]    s_err,
    input  logic [N_SLV*DW-1:0] s_dat_r
);
    logic          req;
    logic          g_ack;
    logic          g_err;
    logic [DW-1:0] g_dat;

    bitsel_gather #(.N_SLV(N_SLV), .DW(DW)) u_gather (
        .grant  (win),
        .s_ack  (s_ack),
        .s_err  (s_err),
        .s_dat_r(s_dat_r),
        .g_ack  (g_ack),
        .g_err  (g_err),
        .g_dat  (g_dat)
    );

    always_comb begin
        req     = m_cyc & m_stb;
        s_cyc   = win & {N_SLV{m_cyc}};
        s_stb   = win & {N_SLV{req}};
        s_we    = m_we;
        s_adr   = m_adr_low;
        s_dat_w = m_dat_w;
        s_sel   = m_sel;
        m_ack   = req & g_ack;
        m_err   = req & (g_err | none);
        m_dat_r = g_dat;
    end

    // R3: never more than one slave cycle
    a_r3_one_slave: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_cyc));

    // R4: idle master means no slave strobe and no ack
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(m_cyc && m_stb) |-> (s_stb == '0) && !m_ack);

    // R7: unselected strobe answered by error, no slave touched
    a_r7_none_err: assert property (@(posedge clk) disable iff (rst)
        (m_cyc && m_stb && none) |-> m_err && (s_stb == '0));

endmodule

// File: rtl/bitsel_reg_path.sv
module bitsel_reg_path
    import bitsel_mux_pkg::*;
#(
    parameter int N_SLV  = 4,
    parameter int LOW_AW = 4,
    parameter int DW     = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_SLV-1:0]    win,
    input  logic                none,
    input  logic                m_cyc,
    input  logic                m_stb,
    input  logic                m_we,
    input  logic [LOW_AW-1:0]   m_adr_low,
    input  logic [DW-1:0]       m_dat_w,
    input  logic [DW/8-1:0]     m_sel,
    output logic                m_ack,
    output logic                m_err,
    output logic [DW-1:0]       m_dat_r,
    output logic [N_SLV-1:0]    s_cyc,
    output logic [N_SLV-1:0]    s_stb,
    output logic                s_we,
    output logic [LOW_AW-1:0]   s_adr,
    output logic [DW-1:0]       s_dat_w,
    output logic [DW/8-1:0]     s_sel,
    input  logic [N_SLV-1:0]    s_ack,
    input  logic [N_SLV-1:0]    s_err,
    input  logic [N_SLV*DW-1:0] s_dat_r
);
    localparam int SW = DW / 8;

    typedef struct packed {
        mux_state_e        st;
        logic [N_SLV-1:0]  grant;
        logic              we;
        logic [LOW_AW-1:0] adr;
        logic [DW-1:0]     wdat;
        logic [SW-1:0]     sel;
        logic              ack;
        logic              err;
        logic [DW-1:0]     rdat;
    } regs_t;

    regs_t         r_d;
    regs_t         r_q;
    logic          g_ack;
    logic          g_err;
    logic [DW-1:0] g_dat;

    bitsel_gather #(.N_SLV(N_SLV), .DW(DW)) u_gather (
        .grant  (r_q.grant),
        .s_ack  (s_ack),
        .s_err  (s_err),
        .s_dat_r(s_dat_r),
        .g_ack  (g_ack),
        .g_err  (g_err),
        .g_dat  (g_dat)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;
        r_d.err = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (m_cyc && m_stb) begin
                    if (none) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_RESP;
                    end else begin
                        r_d.grant = win;
                        r_d.we    = m_we;
                        r_d.adr   = m_adr_low;
                        r_d.wdat  = m_dat_w;
                        r_d.sel   = m_sel;
                        r_d.st    = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (!m_cyc) begin
                    r_d.st = ST_IDLE;
                end else if (g_ack || g_err) begin
                    r_d.ack  = g_ack;
                    r_d.err  = g_err & ~g_ack;
                    r_d.rdat = g_dat;
                    r_d.st   = ST_RESP;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        s_cyc   = (r_q.st == ST_WAIT) ? r_q.grant : '0;
        s_stb   = s_cyc;
        s_we    = r_q.we;
        s_adr   = r_q.adr;
        s_dat_w = r_q.wdat;
        s_sel   = r_q.sel;
        m_ack   = r_q.ack;
        m_err   = r_q.err;
        m_dat_r = r_q.rdat;
    end

    // R9: accepted request reaches the winner one edge later
    a_r9_forward_delay: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && m_cyc && m_stb && !none) |=> (s_stb == $past(win)));

    // R10: response lasts a single cycle
    a_r10_single_resp: assert property (@(posedge clk) disable iff (rst)
        (m_ack || m_err) |=> !(m_ack || m_err));

    // R10: request held while the slave is silent
    a_r10_hold_req: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_WAIT && m_cyc && !g_ack && !g_err) |=>
            ($stable(s_stb) && $stable(s_adr) && $stable(s_dat_w)));

    // R11: master abort clears slave strobes
    a_r11_abort: assert property (@(posedge clk) disable iff (rst)
        ((s_cyc != '0) && !m_cyc) |=> (s_cyc == '0) && !m_ack);

    // R7: unselected request gets an error next cycle
    a_r7_none_err_reg: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && m_cyc && m_stb && none) |=> m_err && (s_stb == '0));

    // R3: never more than one slave cycle
    a_r3_one_slave_reg: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_cyc));

endmodule

// File: rtl/bitsel_bus_mux.sv
module bitsel_bus_mux #(
    parameter int N_SLV   = 4,
    parameter int LOW_AW  = 4,
    parameter int DW      = 16,
    parameter bit REG_OUT = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     m_cyc,
    input  logic                     m_stb,
    input  logic                     m_we,
    input  logic [LOW_AW+N_SLV-1:0]  m_adr,
    input  logic [DW-1:0]            m_dat_w,
    input  logic [DW/8-1:0]          m_sel,
    output logic                     m_ack,
    output logic                     m_err,
    output logic [DW-1:0]            m_dat_r,
    output logic [N_SLV-1:0]         s_cyc,
    output logic [N_SLV-1:0]         s_stb,
    output logic                     s_we,
    output logic [LOW_AW-1:0]        s_adr,
    output logic [DW-1:0]            s_dat_w,
    output logic [DW/8-1:0]          s_sel,
    input  logic [N_SLV-1:0]         s_ack,
    input  logic [N_SLV-1:0]         s_err,
    input  logic [N_SLV*DW-1:0]      s_dat_r
);
    logic [N_SLV-1:0]  sel_bits;
    logic [LOW_AW-1:0] adr_low;
    logic [N_SLV-1:0]  win;
    logic              none;

    assign sel_bits = m_adr[LOW_AW +: N_SLV];
    assign adr_low  = m_adr[LOW_AW-1:0];

    bitsel_pick #(.N_SLV(N_SLV)) u_pick (
        .clk (clk),
        .rst (rst),
        .bits(sel_bits),
        .win (win),
        .none(none)
    );

    generate
        if (REG_OUT) begin : g_reg
            bitsel_reg_path #(.N_SLV(N_SLV), .LOW_AW(LOW_AW), .DW(DW)) u_path (
                .clk(clk), .rst(rst), .win(win), .none(none),
                .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr_low(adr_low),
                .m_dat_w(m_dat_w), .m_sel(m_sel),
                .m_ack(m_ack), .m_err(m_err), .m_dat_r(m_dat_r),
                .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
                .s_dat_w(s_dat_w), .s_sel(s_sel),
                .s_ack(s_ack), .s_err(s_err), .s_dat_r(s_dat_r)
            );
        end else begin : g_comb
            bitsel_comb_path #(.N_SLV(N_SLV), .LOW_AW(LOW_AW), .DW(DW)) u_path (
                .clk(clk), .rst(rst), .win(win), .none(none),
                .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr_low(adr_low),
                .m_dat_w(m_dat_w), .m_sel(m_sel),
                .m_ack(m_ack), .m_err(m_err), .m_dat_r(m_dat_r),
                .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
                .s_dat_w(s_dat_w), .s_sel(s_sel),
                .s_ack(s_ack), .s_err(s_err), .s_dat_r(s_dat_r)
            );
        end
    endgenerate

    // R1: a slave strobe only ever goes to a slave whose select bit is set
    a_r1_strobe_in_field: assert property (@(posedge clk) disable iff (rst)
        ((s_stb & ~sel_bits) == '0) || REG_OUT);

endmodule

// File: tb/sim_bitsel_bus_mux.sv
module sim_bitsel_bus_mux;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int LA = 4;
    localparam int DW = 16;

    localparam logic [N*DW-1:0] SLV_DR = {16'hA0A3, 16'hA0A2, 16'hA0A1, 16'hA0A0};

    // sel, stb, ack, err, expected grant, expected ack, expected err
    localparam logic [18:0] VEC [0:7] = '{
        {4'b0001, 1'b1, 4'b0001, 4'b0000, 4'b0001, 1'b1, 1'b0},
        {4'b0100, 1'b1, 4'b0100, 4'b0000, 4'b0100, 1'b1, 1'b0},
        {4'b1100, 1'b1, 4'b1000, 4'b0000, 4'b0100, 1'b0, 1'b0},
        {4'b1010, 1'b1, 4'b0010, 4'b0000, 4'b0010, 1'b1, 1'b0},
        {4'b1000, 1'b1, 4'b0000, 4'b1000, 4'b1000, 1'b0, 1'b1},
        {4'b0000, 1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b1},
        {4'b0110, 1'b0, 4'b0010, 4'b0000, 4'b0000, 1'b0, 1'b0},
        {4'b1111, 1'b1, 4'b0001, 4'b0000, 4'b0001, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   total = 0;
    int   fails = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // combinational copy
    logic          a_cyc, a_stb, a_we, a_ack, a_err, a_swe;
    logic [LA+N-1:0] a_adr;
    logic [DW-1:0] a_dw, a_dr, a_sdw;
    logic [1:0]    a_sel, a_ssel;
    logic [N-1:0]  a_scyc, a_sstb, a_sack, a_serr;
    logic [LA-1:0] a_sadr;

    // registered copy
    logic          b_cyc, b_stb, b_we, b_ack, b_err, b_swe;
    logic [LA+N-1:0] b_adr;
    logic [DW-1:0] b_dw, b_dr, b_sdw;
    logic [1:0]    b_sel, b_ssel;
    logic [N-1:0]  b_scyc, b_sstb, b_sack, b_serr;
    logic [LA-1:0] b_sadr;

    bitsel_bus_mux #(.N_SLV(N), .LOW_AW(LA), .DW(DW), .REG_OUT(1'b0)) u0 (
        .clk(clk), .rst(rst), .m_cyc(a_cyc), .m_stb(a_stb), .m_we(a_we),
        .m_adr(a_adr), .m_dat_w(a_dw), .m_sel(a_sel),
        .m_ack(a_ack), .m_err(a_err), .m_dat_r(a_dr),
        .s_cyc(a_scyc), .s_stb(a_sstb), .s_we(a_swe), .s_adr(a_sadr),
        .s_dat_w(a_sdw), .s_sel(a_ssel),
        .s_ack(a_sack), .s_err(a_serr), .s_dat_r(SLV_DR)
    );

    bitsel_bus_mux #(.N_SLV(N), .LOW_AW(LA), .DW(DW), .REG_OUT(1'b1)) u1 (
        .clk(clk), .rst(rst), .m_cyc(b_cyc), .m_stb(b_stb), .m_we(b_we),
        .m_adr(b_adr), .m_dat_w(b_dw), .m_sel(b_sel),
        .m_ack(b_ack), .m_err(b_err), .m_dat_r(b_dr),
        .s_cyc(b_scyc), .s_stb(b_sstb), .s_we(b_swe), .s_adr(b_sadr),
        .s_dat_w(b_sdw), .s_sel(b_ssel),
        .s_ack(b_sack), .s_err(b_serr), .s_dat_r(SLV_DR)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog R10 actual=hung expected=complete");
            finish_up();
        end
    end

    initial begin
        a_cyc = 0; a_stb = 0; a_we = 0; a_adr = '0; a_dw = '0; a_sel = '0;
        a_sack = '0; a_serr = '0;
        b_cyc = 0; b_stb = 0; b_we = 0; b_adr = '0; b_dw = '0; b_sel = '0;
        b_sack = '0; b_serr = '0;
        repeat (3) step();

        // R12: reset state of the registered copy
        chk("R12 s_cyc in reset", 32'(b_scyc), 32'h0);
        chk("R12 m_ack/m_err in reset", {30'h0, b_ack, b_err}, 32'h0);
        rst = 1'b0;
        step();
        chk("R12 idle after reset", {26'h0, b_sstb, b_ack, b_err}, 32'h0);

        // combinational table (R1 R2 R3 R4 R5 R6 R7 R8): sampled with no clock edge
        for (int i = 0; i < 8; i++) begin
            logic [18:0]   v;
            logic [DW-1:0] ed;
            v      = VEC[i];
            a_cyc  = 1'b1;
            a_stb  = v[14];
            a_we   = i[0];
            a_adr  = {v[18:15], i[3:0]};
            a_dw   = 16'h1100 + 16'(i);
            a_sel  = 2'(i);
            a_sack = v[13:10];
            a_serr = v[9:6];
            #2;
            chk($sformatf("R1/R2/R3/R4/R8 strobe vec%0d", i), 32'(a_sstb), 32'(v[5:2]));
            chk($sformatf("R6 ack vec%0d", i), 32'(a_ack), 32'(v[1]));
            chk($sformatf("R7/R6 err vec%0d", i), 32'(a_err), 32'(v[0]));
            chk($sformatf("R5 fwd vec%0d", i), {11'h0, a_swe, a_ssel, a_sadr, a_sdw},
                {11'h0, i[0], 2'(i), i[3:0], 16'h1100 + 16'(i)});
            if (v[1]) begin
                ed = '0;
                for (int k = 0; k < N; k++) if (v[2+k]) ed = 16'hA0A0 + 16'(k);
                chk($sformatf("R6 read data vec%0d", i), 32'(a_dr), 32'(ed));
            end
            step();
        end
        a_cyc = 0; a_stb = 0; a_sack = '0; a_serr = '0;

        // registered: transfer to slave 1 (bits 1 and 2 set)
        b_cyc = 1; b_stb = 1; b_we = 1; b_adr = {4'b0110, 4'h5}; b_dw = 16'h5A5A; b_sel = 2'b11;
        #1;
        chk("R9 no strobe before edge", 32'(b_sstb), 32'h0);
        step();
        chk("R9/R2 strobe after one edge", 32'(b_sstb), 32'b0010);
        chk("R5 registered fwd", {11'h0, b_swe, b_ssel, b_sadr, b_sdw}, {11'h0, 1'b1, 2'b11, 4'h5, 16'h5A5A});
        b_sack = 4'b0100;   // ack from a slave that is not selected
        step();
        chk("R6/R10 foreign ack ignored", {31'h0, b_ack}, 32'h0);
        chk("R10 request held", 32'(b_sstb), 32'b0010);
        b_sack = 4'b0010;
        step();
        chk("R9 ack after slave answer", {30'h0, b_ack, b_err}, 32'b10);
        chk("R6 registered read data", 32'(b_dr), 32'hA0A1);
        chk("R10 slave released", 32'(b_sstb), 32'h0);
        b_sack = '0; b_cyc = 0; b_stb = 0;
        step();
        chk("R10 ack single cycle", {30'h0, b_ack, b_err}, 32'h0);

        // registered: no select bit
        b_cyc = 1; b_stb = 1; b_adr = {4'b0000, 4'h3};
        step();
        chk("R7 registered none err", {30'h0, b_ack, b_err}, 32'b01);
        chk("R7 no slave strobed", 32'(b_sstb), 32'h0);
        b_cyc = 0; b_stb = 0;
        step();
        chk("R10 err single cycle", 32'(b_err), 32'h0);

        // registered: master abort
        b_cyc = 1; b_stb = 1; b_adr = {4'b1000, 4'h2};
        step();
        chk("R1 slave 3 strobed", 32'(b_scyc), 32'b1000);
        b_cyc = 0; b_stb = 0;
        step();
        chk("R11 abort drops cyc", 32'(b_scyc), 32'h0);
        chk("R11 no ack after abort", {30'h0, b_ack, b_err}, 32'h0);

        // registered: slave error
        b_cyc = 1; b_stb = 1; b_adr = {4'b0001, 4'h7};
        step();
        chk("R1 slave 0 strobed", 32'(b_sstb), 32'b0001);
        b_serr = 4'b0001;
        step();
        chk("R6 slave err returned", {30'h0, b_ack, b_err}, 32'b01);
        b_serr = '0; b_cyc = 0; b_stb = 0;
        step();
        chk("R10 quiet after err", {30'h0, b_ack, b_err}, 32'h0);

        done = 1'b1;
        finish_up();
    end
endmodule